// File: doc/BRIEF.md
# Count/Compare Interval Timer

This block keeps a free-running up-counter and a comparison value of the same width. Each time the tick-enable input is high, the counter steps by one. It wraps to zero after the all-ones value. When a tick moves the counter onto the comparison value, the block sets a sticky pending flag. It also drives one of eight interrupt lines high. A 3-bit line-select field picks that line.

The interrupt is a level, not a pulse. It stays up until software writes a new comparison value. A freeze bit in the control word stops the counter, and no match can fire while it is set. A single write port loads the counter, the comparison value or the control word. The counter value and the pending flag are always visible on outputs.

Top module: `cmp_timer`

## Requirements
- R1: After reset the counter and the comparison value are zero, the pending flag and the freeze bit are clear, the line select is 0 and all eight interrupt outputs are low.
- R2: In a cycle with `tick_en` high, no counter write and freeze clear, the counter rises by one at the clock edge. Without a tick it holds its value.
- R3: A write with `wr_sel` = 2'b00 loads `wr_data` into the counter at the edge. It takes priority over a tick in the same cycle.
- R4: When a tick moves the counter onto the comparison value, `pending_o` is high from that edge on.
- R5: The pending flag is sticky. Further ticks and counter writes leave it set.
- R6: A write with `wr_sel` = 2'b01 loads the comparison value and clears the pending flag, which lowers the interrupt. The clear wins over a match caused in the same cycle.
- R7: A write with `wr_sel` = 2'b10 loads the control word. Bit 0 is the freeze bit. While it is set, ticks neither change the counter nor raise a match.
- R8: Control bits [3:1] select the line. `irq_o[sel]` equals the pending flag, and every other line is low.
- R9: Changing the line select while pending is set moves the interrupt to the new line in the cycle after the control write.
- R10: The counter wraps from all-ones to zero on a tick. A comparison value of zero matches on that wrap.
- R11: Loading the counter directly with the comparison value does not set the pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count advance strobe |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 00 counter, 01 comparison, 10 control, 11 none |
| wr_data | input | 32 | Write data |
| count_o | output | 32 | Current counter value |
| pending_o | output | 1 | Sticky match flag |
| irq_o | output | 8 | Interrupt lines, at most one high |

## Verification
The main sweep tries every line select with the counter preloaded one, two and three ticks short of the comparison value. This separates a correct match edge from one that comes a tick early or late. It also shows a decoder that drives the wrong line. Other runs cover the following cases:
- a freeze with ticks applied, then a release;
- a counter write that lands exactly on the comparison value, which must not match;
- a comparison write that coincides with a matching tick;
- a wrap from all-ones onto zero.

These runs tell apart the priority between write and tick, the clear-versus-set ordering, and the edge-only detection of a match.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int CNT_W  = 32;
    localparam int LINE_W = 3;
    localparam int NLINES = 1 << LINE_W;

    typedef enum logic [1:0] {
        SEL_COUNT   = 2'b00,
        SEL_COMPARE = 2'b01,
        SEL_CTRL    = 2'b10,
        SEL_NONE    = 2'b11
    } wr_sel_e;

    typedef struct packed {
        logic [CNT_W-1:0]  count;
        logic [CNT_W-1:0]  compare;
        logic              pending;
        logic              freeze;
        logic [LINE_W-1:0] line;
    } tmr_state_t;
endpackage

// File: rtl/tmr_count_next.sv
module tmr_count_next #(
    parameter int W = 32
) (
    input  logic [W-1:0] count_q,
    input  logic [W-1:0] compare_q,
    input  logic         tick,
    input  logic         freeze,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count_d,
    output logic         hit
);
    logic [W-1:0] incr;
    logic         step;

    always_comb begin
        incr = count_q + {{(W-1){1'b0}}, 1'b1};
        step = tick && !freeze;
        if (load) begin
            count_d = load_val;
            hit     = 1'b0;
        end else if (step) begin
            count_d = incr;
            hit     = (incr == compare_q);
        end else begin
            count_d = count_q;
            hit     = 1'b0;
        end
    end
endmodule

// File: rtl/tmr_pend_next.sv
module tmr_pend_next (
    input  logic pending_q,
    input  logic hit,
    input  logic clear,
    output logic pending_d
);
    always_comb begin
        if (clear)
            pending_d = 1'b0;
        else if (hit)
            pending_d = 1'b1;
        else
            pending_d = pending_q;
    end
endmodule

// File: rtl/tmr_line_route.sv
module tmr_line_route #(
    parameter int SEL_W = 3,
    localparam int N = 1 << SEL_W
) (
    input  logic             active,
    input  logic [SEL_W-1:0] sel,
    output logic [N-1:0]     lines
);
    for (genvar i = 0; i < N; i++) begin : g_line
        assign lines[i] = active && (sel == SEL_W'(i));
    end
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  count_o,
    output logic              pending_o,
    output logic [NLINES-1:0] irq_o
);
    tmr_state_t state_d, state_q;

    logic             wr_count, wr_cmp, wr_ctrl;
    logic [CNT_W-1:0] count_nx;
    logic             hit;
    logic             pending_nx;

    assign wr_count = wr_en && (wr_sel == SEL_COUNT);
    assign wr_cmp   = wr_en && (wr_sel == SEL_COMPARE);
    assign wr_ctrl  = wr_en && (wr_sel == SEL_CTRL);

    tmr_count_next #(.W(CNT_W)) u_count (
        .count_q  (state_q.count),
        .compare_q(state_q.compare),
        .tick     (tick_en),
        .freeze   (state_q.freeze),
        .load     (wr_count),
        .load_val (wr_data),
        .count_d  (count_nx),
        .hit      (hit)
    );

    tmr_pend_next u_pend (
        .pending_q(state_q.pending),
        .hit      (hit),
        .clear    (wr_cmp),
        .pending_d(pending_nx)
    );

    tmr_line_route #(.SEL_W(LINE_W)) u_route (
        .active(state_q.pending),
        .sel   (state_q.line),
        .lines (irq_o)
    );

    always_comb begin
        state_d         = state_q;
        state_d.count   = count_nx;
        state_d.pending = pending_nx;
        if (wr_cmp)
            state_d.compare = wr_data;
        if (wr_ctrl) begin
            state_d.freeze = wr_data[0];
            state_d.line   = wr_data[LINE_W:1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign count_o   = state_q.count;
    assign pending_o = state_q.pending;
endmodule

// File: rtl/tmr_timer_chk.sv
module tmr_timer_chk
    import tmr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [CNT_W-1:0]  wr_data,
    input logic [CNT_W-1:0]  count_o,
    input logic              pending_o,
    input logic [NLINES-1:0] irq_o,
    input logic              freeze
);
    AST_IRQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_o) && ((irq_o != '0) == pending_o)); // R8
    AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en && !freeze && !(wr_en && wr_sel == 2'b00)
        |=> count_o == $past(count_o) + 1'b1); // R2
    AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_sel == 2'b00 |=> count_o == $past(wr_data)); // R3
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        pending_o && !(wr_en && wr_sel == 2'b01) |=> pending_o); // R5
    AST_CMP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_sel == 2'b01 |=> !pending_o && irq_o == '0); // R6
    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        freeze && !(wr_en && wr_sel != 2'b11)
        |=> $stable(count_o) && $stable(pending_o)); // R7
endmodule

bind cmp_timer tmr_timer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .count_o  (count_o),
    .pending_o(pending_o),
    .irq_o    (irq_o),
    .freeze   (state_q.freeze)
);

// File: tb/sim_cmp_timer.sv
module sim_cmp_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'b11;
    logic [31:0] wr_data = '0;
    logic [31:0] count_o;
    logic        pending_o;
    logic [7:0]  irq_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmp_timer u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .count_o(count_o),
        .pending_o(pending_o), .irq_o(irq_o)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] sel, logic [31:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        step();
        wr_en = 1'b0; wr_sel = 2'b11;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            tick_en = 1'b1;
            step();
        end
        tick_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            finish_run();
        end
    end

    initial begin
        logic [31:0] c;
        step(); step();
        rst_n = 1'b1;
        #1;
        chk("R1 count", count_o, 0);
        chk("R1 pending", {31'b0, pending_o}, 0);
        chk("R1 irq", {24'b0, irq_o}, 0);

        ticks(5);
        chk("R2 advance", count_o, 5);
        step(); step(); step();
        chk("R2 hold", count_o, 5);

        tick_en = 1'b1;
        wr(2'b00, 32'h1234_0000);
        tick_en = 1'b0;
        chk("R3 write wins", count_o, 32'h1234_0000);

        for (int sel = 0; sel < 8; sel++) begin
            for (int d = 1; d <= 3; d++) begin
                c = 32'h0100_0000 * sel + 32'd77 + d;
                wr(2'b10, {28'b0, sel[2:0], 1'b0});
                wr(2'b01, c);
                wr(2'b00, c - d);
                chk("R4 not yet", {31'b0, pending_o}, 0);
                ticks(d - 1);
                chk("R4 early", {31'b0, pending_o}, 0);
                ticks(1);
                chk("R4 match", {31'b0, pending_o}, 1);
                chk("R8 line", {24'b0, irq_o}, 32'd1 << sel);
                ticks(2);
                wr(2'b00, 32'h5);
                chk("R5 sticky", {31'b0, pending_o}, 1);
                wr(2'b01, c);
                chk("R6 clear", {24'b0, irq_o, 7'b0, pending_o}, 0);
            end
        end

        wr(2'b01, 32'd900);
        wr(2'b00, 32'd900);
        step();
        chk("R11 no match on load", {31'b0, pending_o}, 0);

        wr(2'b10, 32'h1);
        wr(2'b00, 32'd899);
        ticks(4);
        chk("R7 frozen count", count_o, 32'd899);
        chk("R7 no match", {31'b0, pending_o}, 0);
        wr(2'b10, 32'h0);
        ticks(1);
        chk("R7 resume match", {31'b0, pending_o}, 1);

        wr(2'b10, {28'b0, 3'd5, 1'b0});
        chk("R9 moved", {24'b0, irq_o}, 32'h20);

        wr(2'b01, 32'd2000);
        wr(2'b00, 32'd1999);
        tick_en = 1'b1;
        wr(2'b01, 32'd3000);
        tick_en = 1'b0;
        chk("R6 clear beats match", {31'b0, pending_o}, 0);
        chk("R6 count stepped", count_o, 32'd2000);

        wr(2'b01, 32'h0);
        wr(2'b00, 32'hFFFF_FFFF);
        ticks(1);
        chk("R10 wrap", count_o, 0);
        chk("R10 match at zero", {31'b0, pending_o}, 1);

        finish_run();
    end
endmodule